// File: doc/BRIEF.md
# Keyed Power and Clock Mode Controller

This block holds the chip's power mode, core clock divider and core clock source. Software programs it through a simple write-only register bus. Each of the two configuration registers is protected by a key sequence. A write to a configuration register is committed only if it is bracketed by a correct opening key and a correct closing key, in that order, with no other bus write in between. Idle bus cycles between the three writes are allowed.

From the committed state the block drives several outputs: a core clock enable, a divider select, a clock source select, and enables for the peripheral and PLL domains. A low-power mode ends when an enabled interrupt arrives. The deepest mode ends only on the external interrupt. While the PLL is the clock source and reports loss of lock, the core clock enable is withdrawn in the same cycle. A single-cycle PLL interrupt is raised once lock has come back.

The analog PLL, the oscillator and the divider itself lie outside the block. They appear only as the lock input and the select outputs.

Top module: `pwrclk_mode_ctrl`

## Requirements
- R1: A clock-select write takes effect only in this order of writes: 0xAA to address 0, then the data to address 1, then 0x55 to address 2. Cycles with no write may come between them. The new value is visible on the outputs in the cycle after the closing key is written.
- R2: A power-control write takes effect only in this order of writes: 0x01 to address 4, then the data to address 5, then 0xF4 to address 6. Cycles with no write may come between them.
- R3: The sequence is aborted by any of the following: a wrong key value, keys or data written in the wrong order, or any other bus write inside the sequence. After an abort the target register keeps its value, and the next successful commit needs a fresh opening key.
- R4: Power-control data bits 6:4 hold the mode: 000 Active, 001 Pause, 010 Nap, 011 Sleep, 100 Stop. Bits 2:0 hold the divider value 0 to 7, which appears on `clk_div`. Bits 7 and 3 are ignored.
- R5: A committed clock-select value of 0x01 selects the PLL (`clk_src_ext` = 0). A value of 0x03 selects the external clock (`clk_src_ext` = 1). All other values leave the source unchanged.
- R6: A committed mode field of 101, 110 or 111 leaves the mode unchanged. The divider field of that write is still taken.
- R7: `core_clk_en` can be 1 only in Active. `periph_en` and `pll_en` are 1 in Active, Pause and Nap, and 0 in Sleep and Stop.
- R8: In Pause, Nap or Sleep, a request with its mask bit set, or the external interrupt, returns the mode to Active on the next edge. Masked requests have no effect. In Stop, only `ext_irq` wakes the block.
- R9: With the PLL source selected and `pll_locked` low, `core_clk_en` is 0 in the same cycle. With the external source selected, `pll_locked` has no effect on `core_clk_en`.
- R10: After `pll_locked` has been seen low while `pll_en` is 1, `pll_irq` pulses high for exactly one cycle, starting the cycle after lock is seen high again.
- R11: After reset the block is in Active mode with the PLL source, `clk_div` equals `RESET_CD`, and `pll_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| irq_req | input | NIRQ | Interrupt requests that can wake the block |
| irq_mask | input | NIRQ | Per-request wake enable |
| ext_irq | input | 1 | External interrupt; wakes from every mode, including Stop |
| pll_locked | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Core clock enable |
| clk_div | output | 3 | Core clock divider select |
| clk_src_ext | output | 1 | 1 selects the external clock, 0 the PLL |
| periph_en | output | 1 | Peripheral domain enable |
| pll_en | output | 1 | PLL domain enable |
| pwr_mode | output | 3 | Current power mode code |
| pll_irq | output | 1 | One-cycle PLL relock interrupt |

## Verification
The assertions assume the following about the inputs:
- `pll_locked`, `irq_req`, `irq_mask` and `ext_irq` are already synchronous to `clk`.
- At most one bus write arrives per cycle.
- A bus write may arrive in any mode, so a commit can also move the block out of Stop.

The stimulus changes every input only on the falling edge and issues one write per call. It reaches the wake inputs and the lock input only through tasks that hold them for whole cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE = 3'd0,
    PM_PAUSE  = 3'd1,
    PM_NAP    = 3'd2,
    PM_SLEEP  = 3'd3,
    PM_STOP   = 3'd4
  } pmode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_LOADED = 2'd2
  } seq_state_e;

  // power-control field positions, decoded by the mode register
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam int CD_LSB   = 0;
  localparam int CD_W     = 3;

  // clock-select codes
  localparam logic [7:0] SRC_CODE_PLL = 8'h01;
  localparam logic [7:0] SRC_CODE_EXT = 8'h03;

  // key values per protected register (index 0 clock select, 1 power control)
  function automatic logic [7:0] open_key(input int idx);
    return (idx == 0) ? 8'hAA : 8'h01;
  endfunction

  function automatic logic [7:0] close_key(input int idx);
    return (idx == 0) ? 8'h55 : 8'hF4;
  endfunction

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m <= MODE_W'(PM_STOP));
  endfunction

endpackage

// File: rtl/pmc_key_seq.sv
module pmc_key_seq
  import pmc_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter int          DATA_W    = 8,
  parameter logic [ADDR_W-1:0] OPEN_ADDR  = '0,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = '0,
  parameter logic [ADDR_W-1:0] CLOSE_ADDR = '0,
  parameter logic [DATA_W-1:0] OPEN_VAL   = '0,
  parameter logic [DATA_W-1:0] CLOSE_VAL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [DATA_W-1:0] held_data
);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              open_hit, data_hit, close_hit;

  assign open_hit  = (wr_addr == OPEN_ADDR)  && (wr_data == OPEN_VAL);
  assign data_hit  = (wr_addr == DATA_ADDR)  && (state_q == SEQ_ARMED);
  assign close_hit = (wr_addr == CLOSE_ADDR) && (wr_data == CLOSE_VAL) &&
                     (state_q == SEQ_LOADED);

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    commit  = 1'b0;
    if (wr_en) begin
      if (open_hit) begin
        state_d = SEQ_ARMED;
      end else if (data_hit) begin
        state_d = SEQ_LOADED;
        data_d  = wr_data;
      end else if (close_hit) begin
        state_d = SEQ_IDLE;
        commit  = 1'b1;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (wr_en && data_hit) data_q <= data_d;
    end
  end

  assign held_data = data_q;

  // R3: a write that is not the next expected step leaves the sequence idle
  assert_stray_aborts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !open_hit && !data_hit) |=> (state_q == SEQ_IDLE));

  // R1: a commit is never issued in the cycle right after an abort
  assert_no_commit_from_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> !commit);

endmodule

// File: rtl/pmc_pwr_fsm.sv
module pmc_pwr_fsm
  import pmc_pkg::*;
#(
  parameter int              NIRQ     = 4,
  parameter logic [CD_W-1:0] RESET_CD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [MODE_W-1:0] new_mode,
  input  logic [CD_W-1:0]   new_cd,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NIRQ-1:0]   irq_mask,
  input  logic              ext_irq,
  output pmode_e            mode,
  output logic [CD_W-1:0]   cd,
  output logic              core_run,
  output logic              dom_on
);

  pmode_e          mode_q, mode_d;
  logic [CD_W-1:0] cd_q, cd_d;
  logic            wake_any;

  assign wake_any = (|(irq_req & irq_mask)) || ext_irq;

  always_comb begin
    mode_d = mode_q;
    cd_d   = cd_q;
    if (commit) begin
      cd_d = new_cd;
      if (mode_legal(new_mode)) mode_d = pmode_e'(new_mode);
    end else if (mode_q == PM_STOP) begin
      if (ext_irq) mode_d = PM_ACTIVE;
    end else if (mode_q != PM_ACTIVE) begin
      if (wake_any) mode_d = PM_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_ACTIVE;
      cd_q   <= RESET_CD;
    end else begin
      mode_q <= mode_d;
      if (commit) cd_q <= cd_d;
    end
  end

  assign mode     = mode_q;
  assign cd       = cd_q;
  assign core_run = (mode_q == PM_ACTIVE);
  assign dom_on   = (mode_q == PM_ACTIVE) || (mode_q == PM_PAUSE) ||
                    (mode_q == PM_NAP);

  assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(mode_q));

  assert_stop_needs_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == PM_STOP && mode_q == PM_ACTIVE && !$past(commit))
      |-> $past(ext_irq));

  assert_wake_from_light_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PM_ACTIVE && mode_q != PM_STOP && !commit &&
     (|(irq_req & irq_mask))) |=> (mode_q == PM_ACTIVE));

  assert_cd_only_on_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cd_q) |-> $past(commit));

endmodule

// File: rtl/pmc_pll_mon.sv
module pmc_pll_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_locked,
  input  logic pll_on,
  output logic relock_irq
);

  logic lost_q, lost_d;
  logic irq_q, irq_d;

  always_comb begin
    lost_d = lost_q;
    irq_d  = 1'b0;
    if (lost_q && pll_locked) begin
      lost_d = 1'b0;
      irq_d  = 1'b1;
    end else if (pll_on && !pll_locked) begin
      lost_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      lost_q <= lost_d;
      irq_q  <= irq_d;
    end
  end

  assign relock_irq = irq_q;

  assert_irq_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(pll_locked));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

endmodule

// File: rtl/pwrclk_mode_ctrl.sv
module pwrclk_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int NIRQ   = 4,
  parameter logic [ADDR_W-1:0] CLK_OPEN_ADDR  = 3'd0,
  parameter logic [ADDR_W-1:0] CLK_DATA_ADDR  = 3'd1,
  parameter logic [ADDR_W-1:0] CLK_CLOSE_ADDR = 3'd2,
  parameter logic [ADDR_W-1:0] PWR_OPEN_ADDR  = 3'd4,
  parameter logic [ADDR_W-1:0] PWR_DATA_ADDR  = 3'd5,
  parameter logic [ADDR_W-1:0] PWR_CLOSE_ADDR = 3'd6,
  parameter logic [2:0]        RESET_CD       = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NIRQ-1:0]   irq_req,
  input  logic [NIRQ-1:0]   irq_mask,
  input  logic              ext_irq,
  input  logic              pll_locked,
  output logic              core_clk_en,
  output logic [2:0]        clk_div,
  output logic              clk_src_ext,
  output logic              periph_en,
  output logic              pll_en,
  output logic [2:0]        pwr_mode,
  output logic              pll_irq
);

  localparam int NSEQ    = 2;
  localparam int SEQ_CLK = 0;
  localparam int SEQ_PWR = 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic [NSEQ-1:0] seq_commit;
  logic [DATA_W-1:0] seq_data [NSEQ];

  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    pmc_key_seq #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .OPEN_ADDR (g == SEQ_CLK ? CLK_OPEN_ADDR  : PWR_OPEN_ADDR),
      .DATA_ADDR (g == SEQ_CLK ? CLK_DATA_ADDR  : PWR_DATA_ADDR),
      .CLOSE_ADDR(g == SEQ_CLK ? CLK_CLOSE_ADDR : PWR_CLOSE_ADDR),
      .OPEN_VAL  (DATA_W'(open_key(g))),
      .CLOSE_VAL (DATA_W'(close_key(g)))
    ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .commit   (seq_commit[g]),
      .held_data(seq_data[g])
    );
  end

  // clock source register
  logic src_ext_q, src_ext_d;
  logic [DATA_W-1:0] src_word;

  assign src_word = seq_data[SEQ_CLK];

  always_comb begin
    src_ext_d = src_ext_q;
    if (seq_commit[SEQ_CLK]) begin
      if (src_word == DATA_W'(SRC_CODE_PLL))      src_ext_d = 1'b0;
      else if (src_word == DATA_W'(SRC_CODE_EXT)) src_ext_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)               src_ext_q <= 1'b0;
    else if (seq_commit[SEQ_CLK]) src_ext_q <= src_ext_d;
  end

  // power mode and divider
  logic [DATA_W-1:0] pwr_word;
  logic              unused_pwr_bits;
  pmode_e            mode;
  logic              core_run, dom_on;

  assign pwr_word        = seq_data[SEQ_PWR];
  assign unused_pwr_bits = ^{pwr_word[DATA_W-1:MODE_LSB+MODE_W], pwr_word[CD_LSB+CD_W]};

  pmc_pwr_fsm #(
    .NIRQ    (NIRQ),
    .RESET_CD(RESET_CD)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .commit  (seq_commit[SEQ_PWR]),
    .new_mode(pwr_word[MODE_LSB +: MODE_W]),
    .new_cd  (pwr_word[CD_LSB +: CD_W]),
    .irq_req (irq_req),
    .irq_mask(irq_mask),
    .ext_irq (ext_irq),
    .mode    (mode),
    .cd      (clk_div),
    .core_run(core_run),
    .dom_on  (dom_on)
  );

  pmc_pll_mon u_pll (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pll_locked(pll_locked),
    .pll_on    (dom_on),
    .relock_irq(pll_irq)
  );

  assign core_clk_en = core_run && (src_ext_q || pll_locked);
  assign periph_en   = dom_on;
  assign pll_en      = dom_on;
  assign clk_src_ext = src_ext_q;
  assign pwr_mode    = mode;

  assert_src_only_on_commit_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(src_ext_q) |-> $past(seq_commit[SEQ_CLK]));

  assert_gate_on_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!pll_locked && !clk_src_ext) |-> !core_clk_en);

  assert_core_off_low_power_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pwr_mode != 3'd0) |-> !core_clk_en);

  assert_deep_domains_off_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pwr_mode == 3'd3 || pwr_mode == 3'd4) |-> (!periph_en && !pll_en));

endmodule

// File: tb/pwrclk_mode_ctrl_bench.sv
module pwrclk_mode_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] irq_req, irq_mask;
  logic       ext_irq, pll_locked;
  logic       core_clk_en, clk_src_ext, periph_en, pll_en, pll_irq;
  logic [2:0] clk_div, pwr_mode;

  int checks = 0;
  int errors = 0;

  int exp_mode;
  int exp_cd;
  int exp_src;

  always #2.5 clk = ~clk;

  pwrclk_mode_ctrl u_pwrclk_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_req(irq_req), .irq_mask(irq_mask), .ext_irq(ext_irq), .pll_locked(pll_locked),
    .core_clk_en(core_clk_en), .clk_div(clk_div), .clk_src_ext(clk_src_ext),
    .periph_en(periph_en), .pll_en(pll_en), .pwr_mode(pwr_mode), .pll_irq(pll_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pwr_seq(input logic [7:0] k1, input logic [7:0] d, input logic [7:0] k2);
    wr(3'd4, k1); wr(3'd5, d); wr(3'd6, k2);
  endtask

  task automatic clk_seq(input logic [7:0] k1, input logic [7:0] d, input logic [7:0] k2);
    wr(3'd0, k1); wr(3'd1, d); wr(3'd2, k2);
  endtask

  // all outputs against the bench model
  task automatic chk_outs(input string req);
    chk({req, " mode"}, int'(pwr_mode), exp_mode);
    chk({req, " div"}, int'(clk_div), exp_cd);
    chk({req, " src"}, int'(clk_src_ext), exp_src);
    chk({req, " core"}, int'(core_clk_en),
        ((exp_mode == 0) && (exp_src == 1 || pll_locked)) ? 1 : 0);
    chk({req, " periph"}, int'(periph_en), (exp_mode <= 2) ? 1 : 0);
    chk({req, " pll_en"}, int'(pll_en), (exp_mode <= 2) ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    irq_req = '0; irq_mask = '0; ext_irq = 1'b0; pll_locked = 1'b1;
    exp_mode = 0; exp_cd = 0; exp_src = 0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    chk_outs("R11");
    chk("R11 pll_irq", int'(pll_irq), 0);

    // R2 with idle gaps between steps: Pause, divider 5
    wr(3'd4, 8'h01); idle(2); wr(3'd5, 8'h15); idle(3); wr(3'd6, 8'hF4);
    exp_mode = 1; exp_cd = 5;
    chk_outs("R2");
    irq_req = 4'h1; irq_mask = 4'h1; @(negedge clk); irq_req = '0; irq_mask = '0;
    exp_mode = 0;
    chk_outs("R8");

    // R4 R6 R7 R8: every mode code with every divider value
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < 8; c++) begin
        logic [7:0] d;
        d = {c[0], m[2:0], c[0], c[2:0]};
        pwr_seq(8'h01, d, 8'hF4);
        if (m <= 4) exp_mode = m;
        exp_cd = c;
        chk_outs((m <= 4) ? "R4_R7" : "R6");
        if (exp_mode == 4) begin
          irq_req = 4'hF; irq_mask = 4'hF; @(negedge clk);
          irq_req = '0; irq_mask = '0;
          chk_outs("R8 stop ignores irq");
          ext_irq = 1'b1; @(negedge clk); ext_irq = 1'b0;
          exp_mode = 0;
          chk_outs("R8 stop ext wake");
        end else if (exp_mode != 0) begin
          irq_req = 4'h2; irq_mask = 4'h1; @(negedge clk);
          chk_outs("R8 masked");
          irq_mask = 4'h2; @(negedge clk);
          irq_req = '0; irq_mask = '0;
          exp_mode = 0;
          chk_outs("R8 wake");
        end
      end
    end

    // R3 aborts: divider is 7, mode Active
    pwr_seq(8'h02, 8'h20, 8'hF4);
    chk_outs("R3 wrong open key");
    pwr_seq(8'h01, 8'h20, 8'hF5);
    chk_outs("R3 wrong close key");
    wr(3'd4, 8'h01); wr(3'd5, 8'h20); wr(3'd1, 8'h03); wr(3'd6, 8'hF4);
    chk_outs("R3 stray write");
    wr(3'd5, 8'h20); wr(3'd4, 8'h01); wr(3'd6, 8'hF4);
    chk_outs("R3 wrong order");
    wr(3'd6, 8'hF4);
    chk_outs("R3 close alone");
    clk_seq(8'hAB, 8'h03, 8'h55);
    chk_outs("R3 clock wrong key");
    pwr_seq(8'h01, 8'h22, 8'hF4);
    exp_mode = 2; exp_cd = 2;
    chk_outs("R3 restart commits");
    ext_irq = 1'b1; @(negedge clk); ext_irq = 1'b0;
    exp_mode = 0;
    chk_outs("R8 ext wakes nap");

    // R5 R1: every clock-select value
    for (int v = 0; v < 256; v++) begin
      clk_seq(8'hAA, v[7:0], 8'h55);
      if (v == 1) exp_src = 0;
      else if (v == 3) exp_src = 1;
      chk("R5 src", int'(clk_src_ext), exp_src);
    end
    clk_seq(8'hAA, 8'h01, 8'h55);
    exp_src = 0;
    chk_outs("R1");

    // R9 R10: loss of lock on the PLL source
    pll_locked = 1'b0; #1;
    chk("R9 gated", int'(core_clk_en), 0);
    @(negedge clk);
    chk("R10 no irq while unlocked", int'(pll_irq), 0);
    pll_locked = 1'b1; #1;
    chk("R9 released", int'(core_clk_en), 1);
    @(negedge clk);
    chk("R10 pulse", int'(pll_irq), 1);
    @(negedge clk);
    chk("R10 one cycle", int'(pll_irq), 0);

    // R9: external source ignores lock
    clk_seq(8'hAA, 8'h03, 8'h55);
    exp_src = 1;
    pll_locked = 1'b0; #1;
    chk("R9 ext ungated", int'(core_clk_en), 1);
    @(negedge clk);
    pll_locked = 1'b1;
    idle(3);
    chk("R10 idle after pulse", int'(pll_irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule